// File: doc/BRIEF.md
# Warp Issue Scheduler

This block chooses, every clock cycle, which warp of a multi-warp core may send its next instruction to fetch. It keeps one bit per warp saying the warp is running and a second bit saying the warp already has an instruction in flight between scheduling and decode. Among the running warps with no instruction in flight, the one with the smallest index wins. The winner's in-flight bit is set at the next edge. The decode stage clears that bit with a release command, unless the instruction it decoded asks to hold further fetch for that warp.

Alongside the chosen index, the block presents the chosen warp's program counter and per-thread enable mask. These are held in registers inside the block. A spawn command brings more warps to life. It takes a requested warp count and a start address, enables warps 1 up to one below the smaller of the request and the warp count, and loads each of them with that address and a mask naming only thread 0. One cycle later the block reports which warps the spawn covered, with warp 0 always included. A free-running counter records how many scheduling decisions have been made.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, only warp 0 is running. Its thread mask is 1 (thread 0 only, bit 0 = thread 0), its PC is the RESET_PC parameter, no warp is in flight and the issue count is 0. In the first cycle after reset, warp 0 is therefore offered with `sched_valid` high.
- R2: Whenever `sched_valid` is high, `sched_warp` is the lowest index among the warps that are running and not in flight.
- R3: A warp offered in a cycle is in flight from the next edge. It is not offered again until decode frees it.
- R4: A release with `rel_hold` high leaves the named warp in flight.
- R5: A release with `rel_hold` low makes the named warp eligible in the same cycle. If that warp is then offered, it is in flight again from the next edge.
- R6: A spawn request with count N sets warps 1 to min(N,NUM_WARPS)-1 running from the next edge, each with PC `spawn_pc` and thread mask 1. The PC and mask of warp 0 and the in-flight bits of all warps do not change.
- R7: One cycle after `spawn_valid`, `spawn_ack` is high for one cycle. `spawn_mask` then has bit 0 set plus bit i for each warp that spawn enabled. For N of 0 or 1 it is 1, and no warp changes.
- R8: `issue_count` rises by exactly one at each edge where `sched_valid` was high and is unchanged otherwise.
- R9: `sched_valid` is low when no running warp is free of an in-flight instruction.
- R10: A spawn count larger than NUM_WARPS enables every warp from 1 to NUM_WARPS-1. A spawn also overwrites the PC of a warp that was already running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| rel_valid | input | 1 | Decode release command present |
| rel_warp | input | WID_W | Warp named by the release |
| rel_hold | input | 1 | Decoded instruction holds further fetch; warp stays in flight |
| spawn_valid | input | 1 | Spawn command present |
| spawn_count | input | SPAWN_W | Requested total warp count |
| spawn_pc | input | PC_W | Start address for spawned warps |
| sched_valid | output | 1 | A warp is offered this cycle |
| sched_warp | output | WID_W | Index of the offered warp |
| sched_pc | output | PC_W | PC held for the offered warp |
| sched_tmask | output | NUM_THREADS | Thread mask held for the offered warp |
| spawn_ack | output | 1 | Spawn result valid |
| spawn_mask | output | NUM_WARPS | Warps covered by the last spawn, bit 0 always set |
| issue_count | output | CNT_W | Number of scheduling decisions since reset |

## Verification
Selection is first tried with a single running warp. This shows that a warp is blocked after it is offered, that a held release keeps it blocked and that a free release opens it in the same cycle. A spawn of three warps while warp 0 is in flight makes warps 1 and 2 eligible together, which separates lowest-index choice from plain arrival order. It also shows that warp 3 stays idle. An oversized spawn and a spawn of one check clipping, the reported mask, and that warp 0's PC survives while an already running warp's PC is overwritten.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  // Action decoded from a decode-stage release command
  typedef enum logic [1:0] {
    REL_NONE = 2'b00,
    REL_KEEP = 2'b01,
    REL_FREE = 2'b10
  } rel_act_e;

  function automatic rel_act_e rel_action(input logic vld, input logic hold);
    if (!vld)     return REL_NONE;
    else if (hold) return REL_KEEP;
    else          return REL_FREE;
  endfunction

endpackage

// File: rtl/warp_pick.sv
module warp_pick #(
  parameter int unsigned NUM_WARPS = 4,
  localparam int unsigned WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic [NUM_WARPS-1:0] elig,
  output logic                 pick_valid,
  output logic [WID_W-1:0]     pick_idx,
  output logic [NUM_WARPS-1:0] pick_onehot
);

  logic [NUM_WARPS:0] below;

  assign below[0] = 1'b0;

  for (genvar i = 0; i < NUM_WARPS; i++) begin : g_chain
    assign below[i+1]     = below[i] | elig[i];
    assign pick_onehot[i] = elig[i] & ~below[i];
  end

  assign pick_valid = below[NUM_WARPS];

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      if (pick_onehot[i]) pick_idx = pick_idx | WID_W'(i);
    end
  end

endmodule

// File: rtl/spawn_decode.sv
module spawn_decode #(
  parameter int unsigned NUM_WARPS = 4,
  parameter int unsigned SPAWN_W   = 8
) (
  input  logic [SPAWN_W-1:0]   req_count,
  output logic [NUM_WARPS-1:0] grant
);

  // Warp 0 is never touched by a spawn
  assign grant[0] = 1'b0;

  // Warp i is enabled when the request covers more than i warps;
  // indices at or above NUM_WARPS do not exist, so clipping is implicit
  for (genvar i = 1; i < NUM_WARPS; i++) begin : g_cmp
    if (i < (1 << SPAWN_W)) begin : g_reach
      assign grant[i] = (req_count > SPAWN_W'(i));
    end else begin : g_out_of_reach
      assign grant[i] = 1'b0;
    end
  end

endmodule

// File: rtl/warp_state.sv
module warp_state
  import warp_sched_pkg::*;
#(
  parameter int unsigned NUM_WARPS   = 4,
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned PC_W        = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int unsigned WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  rel_act_e               rel_act,
  input  logic [WID_W-1:0]       rel_warp,
  input  logic [NUM_WARPS-1:0]   sched_onehot,
  input  logic                   spawn_en,
  input  logic [NUM_WARPS-1:0]   spawn_grant,
  input  logic [PC_W-1:0]        spawn_pc,
  input  logic [WID_W-1:0]       rd_idx,
  output logic [NUM_WARPS-1:0]   elig,
  output logic [PC_W-1:0]        rd_pc,
  output logic [NUM_THREADS-1:0] rd_tmask
);

  localparam logic [NUM_THREADS-1:0] TM_FIRST = NUM_THREADS'(1);

  logic [NUM_WARPS-1:0]   active_q, active_d;
  logic [NUM_WARPS-1:0]   flight_q, flight_d;
  logic [NUM_WARPS-1:0]   free_vec;
  logic [NUM_WARPS-1:0]   load_en;
  logic [PC_W-1:0]        pc_q [NUM_WARPS];
  logic [NUM_THREADS-1:0] tm_q [NUM_WARPS];

  // ---------------- next state ----------------
  always_comb begin
    for (int i = 0; i < NUM_WARPS; i++) begin
      free_vec[i] = (rel_act == REL_FREE) && (rel_warp == WID_W'(i));
    end
    load_en  = spawn_en ? spawn_grant : '0;
    // release is applied ahead of this cycle's choice
    elig     = active_q & ~(flight_q & ~free_vec);
    flight_d = (flight_q & ~free_vec) | sched_onehot;
    active_d = active_q | load_en;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= NUM_WARPS'(1);
      flight_q <= '0;
    end else begin
      active_q <= active_d;
      flight_q <= flight_d;
    end
  end

  for (genvar i = 0; i < NUM_WARPS; i++) begin : g_ctx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q[i] <= (i == 0) ? RESET_PC : '0;
        tm_q[i] <= (i == 0) ? TM_FIRST : '0;
      end else if (load_en[i]) begin
        pc_q[i] <= spawn_pc;
        tm_q[i] <= TM_FIRST;
      end
    end
  end

  // ---------------- read port ----------------
  always_comb begin
    rd_pc    = '0;
    rd_tmask = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      if (rd_idx == WID_W'(i)) begin
        rd_pc    = pc_q[i];
        rd_tmask = tm_q[i];
      end
    end
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int unsigned NUM_WARPS   = 4,
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned PC_W        = 32,
  parameter int unsigned SPAWN_W     = 8,
  parameter int unsigned CNT_W       = 32,
  parameter logic [PC_W-1:0] RESET_PC = PC_W'(32'h100),
  localparam int unsigned WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rel_valid,
  input  logic [WID_W-1:0]       rel_warp,
  input  logic                   rel_hold,
  input  logic                   spawn_valid,
  input  logic [SPAWN_W-1:0]     spawn_count,
  input  logic [PC_W-1:0]        spawn_pc,
  output logic                   sched_valid,
  output logic [WID_W-1:0]       sched_warp,
  output logic [PC_W-1:0]        sched_pc,
  output logic [NUM_THREADS-1:0] sched_tmask,
  output logic                   spawn_ack,
  output logic [NUM_WARPS-1:0]   spawn_mask,
  output logic [CNT_W-1:0]       issue_count
);

  logic [NUM_WARPS-1:0] elig;
  logic [NUM_WARPS-1:0] pick_onehot;
  logic [NUM_WARPS-1:0] spawn_grant;
  rel_act_e             rel_act;

  assign rel_act = rel_action(rel_valid, rel_hold);

  spawn_decode #(
    .NUM_WARPS (NUM_WARPS),
    .SPAWN_W   (SPAWN_W)
  ) u_spawn (
    .req_count (spawn_count),
    .grant     (spawn_grant)
  );

  warp_pick #(
    .NUM_WARPS (NUM_WARPS)
  ) u_pick (
    .elig        (elig),
    .pick_valid  (sched_valid),
    .pick_idx    (sched_warp),
    .pick_onehot (pick_onehot)
  );

  warp_state #(
    .NUM_WARPS   (NUM_WARPS),
    .NUM_THREADS (NUM_THREADS),
    .PC_W        (PC_W),
    .RESET_PC    (RESET_PC)
  ) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .rel_act      (rel_act),
    .rel_warp     (rel_warp),
    .sched_onehot (pick_onehot),
    .spawn_en     (spawn_valid),
    .spawn_grant  (spawn_grant),
    .spawn_pc     (spawn_pc),
    .rd_idx       (sched_warp),
    .elig         (elig),
    .rd_pc        (sched_pc),
    .rd_tmask     (sched_tmask)
  );

  // ---------------- spawn result and issue counter ----------------
  logic                 ack_d;
  logic [NUM_WARPS-1:0] mask_d;
  logic [CNT_W-1:0]     cnt_d;

  always_comb begin
    ack_d  = spawn_valid;
    mask_d = spawn_valid ? (spawn_grant | NUM_WARPS'(1)) : spawn_mask;
    cnt_d  = issue_count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spawn_ack <= 1'b0;
    end else begin
      spawn_ack <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spawn_mask <= NUM_WARPS'(1);
    end else if (spawn_valid) begin
      spawn_mask <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_count <= '0;
    end else if (sched_valid) begin
      issue_count <= cnt_d;
    end
  end

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int unsigned NUM_WARPS   = 4,
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned CNT_W       = 32,
  localparam int unsigned WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rel_valid,
  input logic [WID_W-1:0]       rel_warp,
  input logic                   rel_hold,
  input logic                   spawn_valid,
  input logic                   sched_valid,
  input logic [WID_W-1:0]       sched_warp,
  input logic [NUM_THREADS-1:0] sched_tmask,
  input logic                   spawn_ack,
  input logic [NUM_WARPS-1:0]   spawn_mask,
  input logic [CNT_W-1:0]       issue_count,
  input logic [NUM_WARPS-1:0]   elig
);

  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    sched_valid |-> (elig[sched_warp] &&
      ((elig & ((NUM_WARPS'(1) << sched_warp) - NUM_WARPS'(1))) == '0))); // R2

  AST_NO_REPICK: assert property (@(posedge clk) disable iff (!rst_n)
    sched_valid |=> !(sched_valid && (sched_warp == $past(sched_warp)) &&
      !(rel_valid && !rel_hold && (rel_warp == $past(sched_warp))))); // R3

  AST_SPAWN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    spawn_valid |=> (spawn_ack && spawn_mask[0])); // R7

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !spawn_valid |=> !spawn_ack); // R7

  AST_TMASK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    sched_valid |-> (sched_tmask == NUM_THREADS'(1))); // R6

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sched_valid |=> (issue_count == $past(issue_count) + CNT_W'(1))); // R8

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_valid |=> $stable(issue_count)); // R8

  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_valid |-> (elig == '0)); // R9

endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS   (NUM_WARPS),
  .NUM_THREADS (NUM_THREADS),
  .CNT_W       (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rel_valid   (rel_valid),
  .rel_warp    (rel_warp),
  .rel_hold    (rel_hold),
  .spawn_valid (spawn_valid),
  .sched_valid (sched_valid),
  .sched_warp  (sched_warp),
  .sched_tmask (sched_tmask),
  .spawn_ack   (spawn_ack),
  .spawn_mask  (spawn_mask),
  .issue_count (issue_count),
  .elig        (elig)
);

// File: tb/warp_issue_sched_tb.sv
`timescale 1ns/1ps
module warp_issue_sched_tb;

  localparam int NW = 4;
  localparam int NT = 4;
  localparam int WW = 2;
  localparam int PW = 32;
  localparam int SW = 8;
  localparam int CW = 32;
  localparam logic [PW-1:0] RPC = 32'h100;

  logic          clk;
  logic          rst_n;
  logic          rel_valid;
  logic [WW-1:0] rel_warp;
  logic          rel_hold;
  logic          spawn_valid;
  logic [SW-1:0] spawn_count;
  logic [PW-1:0] spawn_pc;
  logic          sched_valid;
  logic [WW-1:0] sched_warp;
  logic [PW-1:0] sched_pc;
  logic [NT-1:0] sched_tmask;
  logic          spawn_ack;
  logic [NW-1:0] spawn_mask;
  logic [CW-1:0] issue_count;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  warp_issue_sched #(
    .NUM_WARPS (NW), .NUM_THREADS (NT), .PC_W (PW),
    .SPAWN_W (SW), .CNT_W (CW), .RESET_PC (RPC)
  ) u_dut (
    .clk (clk), .rst_n (rst_n),
    .rel_valid (rel_valid), .rel_warp (rel_warp), .rel_hold (rel_hold),
    .spawn_valid (spawn_valid), .spawn_count (spawn_count), .spawn_pc (spawn_pc),
    .sched_valid (sched_valid), .sched_warp (sched_warp), .sched_pc (sched_pc),
    .sched_tmask (sched_tmask), .spawn_ack (spawn_ack), .spawn_mask (spawn_mask),
    .issue_count (issue_count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // drive point: just after the falling edge; sample 1 ns later
  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rel_valid = 0; rel_warp = 0; rel_hold = 0;
    spawn_valid = 0; spawn_count = 0; spawn_pc = 0;
    repeat (3) @(posedge clk);
    step(); rst_n = 1'b1; #1;
    check("R1 valid", sched_valid, 1);
    check("R1 warp", sched_warp, 0);
    check("R1 pc", sched_pc, RPC);
    check("R1 tmask", sched_tmask, 1);
    check("R1 count", issue_count, 0);
    check("R1 spawn_ack", spawn_ack, 0);
    step(); #1;
    check("R3 no repick", sched_valid, 0);
    check("R9 idle", sched_valid, 0);
    check("R8 count", issue_count, 1);
  endtask

  task automatic t_hold_release();
    step(); rel_valid = 1; rel_warp = 0; rel_hold = 1; #1;
    check("R4 hold same cycle", sched_valid, 0);
    step(); rel_valid = 0; rel_hold = 0; #1;
    check("R4 hold after", sched_valid, 0);
    check("R4 count", issue_count, 1);
  endtask

  task automatic t_free_release();
    step(); rel_valid = 1; rel_warp = 0; rel_hold = 0; #1;
    check("R5 same cycle valid", sched_valid, 1);
    check("R5 same cycle warp", sched_warp, 0);
    step(); rel_valid = 0; #1;
    check("R5 restalled", sched_valid, 0);
    check("R8 count", issue_count, 2);
  endtask

  task automatic t_spawn();
    step(); spawn_valid = 1; spawn_count = 3; spawn_pc = 32'hA0; #1;
    check("R7 ack latency", spawn_ack, 0);
    check("R6 not yet active", sched_valid, 0);
    step(); spawn_valid = 0; #1;
    check("R7 ack", spawn_ack, 1);
    check("R7 mask", spawn_mask, 4'b0111);
    check("R2 lowest warp", sched_warp, 1);
    check("R6 pc w1", sched_pc, 32'hA0);
    check("R6 tmask w1", sched_tmask, 1);
    step(); #1;
    check("R7 ack pulse", spawn_ack, 0);
    check("R2 next warp valid", sched_valid, 1);
    check("R2 next warp", sched_warp, 2);
    check("R6 pc w2", sched_pc, 32'hA0);
    step(); #1;
    check("R6 warp3 idle", sched_valid, 0);
    check("R8 count", issue_count, 4);
  endtask

  task automatic t_spawn_clip();
    step(); spawn_valid = 1; spawn_count = 9; spawn_pc = 32'hC0; #1;
    step(); spawn_valid = 0; #1;
    check("R10 mask", spawn_mask, 4'b1111);
    check("R10 valid", sched_valid, 1);
    check("R10 warp3", sched_warp, 3);
    check("R10 pc w3", sched_pc, 32'hC0);
    step(); #1;
    check("R10 stalls kept", sched_valid, 0);
    check("R8 count", issue_count, 5);
  endtask

  task automatic t_spawn_small();
    step(); spawn_valid = 1; spawn_count = 1; spawn_pc = 32'hEE; #1;
    step(); spawn_valid = 0; #1;
    check("R7 small ack", spawn_ack, 1);
    check("R7 small mask", spawn_mask, 4'b0001);
    check("R7 small none", sched_valid, 0);
    step(); rel_valid = 1; rel_warp = 0; rel_hold = 0; #1;
    check("R6 w0 warp", sched_warp, 0);
    check("R6 w0 pc kept", sched_pc, RPC);
    step(); rel_warp = 1; #1;
    check("R10 w1 warp", sched_warp, 1);
    check("R10 w1 pc overwritten", sched_pc, 32'hC0);
    step(); rel_valid = 0; #1;
    check("R9 idle end", sched_valid, 0);
    check("R8 final count", issue_count, 7);
  endtask

  initial begin
    t_reset();
    t_hold_release();
    t_free_release();
    t_spawn();
    t_spawn_clip();
    t_spawn_small();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule